// File: doc/BRIEF.md
# Configuration Space Index/Data Window Bridge

This block gives a host CPU access to device configuration space through two registers. One is a 32-bit index register that holds the target configuration address and an enable flag in its top bit. The other is a data window. A CPU access to the window can be 1, 2 or 4 bytes wide. While the enable flag is set, each window access becomes one request on a downstream configuration port. The request carries the formed address, the access size in bytes and the write data. A read then waits for the response data.

While the enable flag is clear, the block answers the CPU on its own. Window writes are dropped. Window reads return all-ones at the access width. No downstream request is made in either case.

For byte and halfword accesses, the low two offset bits of the window are ORed into the target address. For word accesses, the index register value is used as it is. A build-time parameter selects big-endian lane order: halfword and word data are then byte-reversed in both directions. Only one window access is in flight at a time.

Top module: `cfg_window_bridge`

## Requirements
- R1: The index register is written as a full 32-bit value and always reads back what was last written. Synchronous reset clears it to zero, which leaves window access disabled.
- R2: A window write made while index bit 31 is clear issues no downstream request. It completes (`win_done`) one cycle after acceptance, and `win_rdata` is zero.
- R3: A window read made while index bit 31 is clear issues no downstream request. It completes one cycle after acceptance, returning 0x000000FF for a byte, 0x0000FFFF for a halfword and 0xFFFFFFFF for a word.
- R4: With the enable flag set, a byte or halfword access sends `dn_addr` = index value OR the 2-bit window offset, zero-extended.
- R5: With the enable flag set, a word access sends `dn_addr` equal to the index value, whatever the window offset is.
- R6: `win_size` code 0 selects a byte, 1 a halfword, and 2 or 3 a word. `dn_size` carries 1, 2 or 4 to match.
- R7: In the default lane order, write data goes downstream unswapped. Bits above the access width are forced to zero, and a completed write returns zero on `win_rdata`.
- R8: A read returns `dn_rdata` captured on `dn_rvalid`, with bits above the access width cleared. `win_done` rises one cycle after the response.
- R9: A request holds `dn_valid`, `dn_addr` and `dn_wdata` steady until `dn_ready`. `win_ready` stays low from acceptance until completion, so at most one transaction is outstanding.
- R10: With `BIG_ENDIAN` = 1, halfword data swaps its two low bytes and word data reverses all four bytes. This applies to writes going down and to reads coming back. Byte data is never swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| areg_we | input | 1 | Write strobe for the index register |
| areg_wdata | input | 32 | New index register value |
| areg_rdata | output | 32 | Current index register value |
| win_req | input | 1 | Window access request |
| win_we | input | 1 | 1 = window write, 0 = window read |
| win_off | input | 2 | Byte offset of the access inside the window |
| win_size | input | 2 | Access width code (0 byte, 1 halfword, 2/3 word) |
| win_wdata | input | 32 | Window write data, right-aligned |
| win_ready | output | 1 | Block can accept a window access this cycle |
| win_done | output | 1 | One-cycle pulse: window access finished |
| win_rdata | output | 32 | Read result, valid while `win_done` is high |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream accepts the request |
| dn_we | output | 1 | Downstream request is a write |
| dn_addr | output | 32 | Formed configuration address |
| dn_size | output | 3 | Access size in bytes (1, 2 or 4) |
| dn_wdata | output | 32 | Lane-ordered write data |
| dn_rvalid | input | 1 | Downstream read data valid |
| dn_rdata | input | 32 | Downstream read data |

## Verification
A wrong latched request shows on the downstream port in the cycle after acceptance. A bad address, size or lane order appears on `dn_addr`, `dn_size` or `dn_wdata`. A wrong enable decision shows as a missing or unexpected `dn_valid`. A sequencer stuck in a wrong state shows within a few cycles: `win_done` never rises, `win_ready` comes back early, or the request drops before `dn_ready`. A corrupted response path shows only on `win_rdata` during the single `win_done` cycle, so every read result is compared in exactly that cycle.

// File: rtl/cfgw_pkg.sv
// cfgw_pkg: shared widths, size codes, sequencer states and data helpers
// for the configuration window bridge. Assumes a 32-bit data path made of
// 8-bit byte lanes.
package cfgw_pkg;

    localparam int CFGW_AW    = 32;
    localparam int CFGW_DW    = 32;
    localparam int CFGW_LANES = CFGW_DW / 8;
    localparam int CFGW_SZW   = 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } cfgw_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } cfgw_state_e;

    // Map the reserved size code onto a word access.
    function automatic cfgw_size_e cfgw_norm(input logic [1:0] code);
        return (code == 2'd3) ? SZ_WORD : cfgw_size_e'(code);
    endfunction

    // Number of bytes moved by a normalised size code.
    function automatic logic [CFGW_SZW-1:0] cfgw_bytes(input cfgw_size_e sz);
        case (sz)
            SZ_BYTE: return CFGW_SZW'(1);
            SZ_HALF: return CFGW_SZW'(2);
            default: return CFGW_SZW'(4);
        endcase
    endfunction

    // Ones over the lanes an access of this size covers.
    function automatic logic [CFGW_DW-1:0] cfgw_mask(input cfgw_size_e sz);
        logic [CFGW_DW-1:0] m;
        m = '0;
        for (int i = 0; i < CFGW_LANES; i++) begin
            if (i < int'(cfgw_bytes(sz))) m[8*i +: 8] = 8'hFF;
        end
        return m;
    endfunction

    // Reverse the order of the low n byte lanes. Lanes above n are cleared.
    function automatic logic [CFGW_DW-1:0] cfgw_swap(input logic [CFGW_DW-1:0] d,
                                                     input int n);
        logic [CFGW_DW-1:0] o;
        o = '0;
        for (int i = 0; i < CFGW_LANES; i++) begin
            if (i < n) o[8*i +: 8] = d[8*(n-1-i) +: 8];
        end
        return o;
    endfunction

endpackage

// File: rtl/cfgw_index_reg.sv
// cfgw_index_reg: holds the 32-bit configuration index register and
// exposes its enable flag. Assumes the CPU writes the whole register at
// once. Reset clears it, which disables window access.
module cfgw_index_reg #(
    parameter int AW     = 32,
    parameter int EN_BIT = AW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] value,
    output logic          enabled
);

    logic [AW-1:0] idx_q;

    // Load the full index value on a write strobe; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     idx_q <= '0;
        else if (wr_en) idx_q <= wr_data;
    end

    assign value   = idx_q;
    assign enabled = idx_q[EN_BIT];

endmodule

// File: rtl/cfgw_addr_form.sv
// cfgw_addr_form: builds the downstream configuration address from the
// index register and the window offset. Sub-word accesses OR the offset
// into the low bits; word accesses take the index value unchanged.
// Purely combinational.
module cfgw_addr_form
    import cfgw_pkg::*;
#(
    parameter int AW    = 32,
    parameter int OFF_W = 2
) (
    input  logic [AW-1:0]    index_val,
    input  logic [OFF_W-1:0] offset,
    input  cfgw_size_e       size,
    output logic [AW-1:0]    addr
);

    logic [AW-1:0] off_ext;

    // Zero-extend the offset to the address width.
    always_comb off_ext = {{(AW-OFF_W){1'b0}}, offset};

    // Merge the offset for byte/halfword accesses only.
    always_comb begin
        if (size == SZ_WORD) addr = index_val;
        else                 addr = index_val | off_ext;
    end

endmodule

// File: rtl/cfgw_lane_fmt.sv
// cfgw_lane_fmt: sizes and orders data in both directions. Write data is
// masked to the access width and, for a big-endian build, byte-reversed
// across that width. Read data gets the same treatment on return.
// Combinational; the lane order is fixed by a parameter at elaboration.
module cfgw_lane_fmt
    import cfgw_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b0,
    parameter int DW         = CFGW_DW
) (
    input  logic [DW-1:0] wr_in,
    input  cfgw_size_e    wr_size,
    output logic [DW-1:0] wr_out,
    input  logic [DW-1:0] rd_in,
    input  cfgw_size_e    rd_size,
    output logic [DW-1:0] rd_out
);

    generate
        if (BIG_ENDIAN) begin : g_big
            // Reverse lanes within the access width in each direction.
            always_comb wr_out = cfgw_swap(wr_in, int'(cfgw_bytes(wr_size)));
            always_comb rd_out = cfgw_swap(rd_in, int'(cfgw_bytes(rd_size)));
        end else begin : g_little
            // Pass data through with upper lanes cleared.
            always_comb wr_out = wr_in & cfgw_mask(wr_size);
            always_comb rd_out = rd_in & cfgw_mask(rd_size);
        end
    endgenerate

endmodule

// File: rtl/cfgw_seq.sv
// cfgw_seq: sequences one window access at a time. On acceptance it either
// answers locally (enable flag clear) or latches a downstream request.
// It holds the request until the downstream side takes it, waits for read
// data, and pulses completion with the result.
// Assumes the formatted inputs are stable in the cycle they are sampled.
module cfgw_seq
    import cfgw_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int SZW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           acc_req,
    input  logic           acc_we,
    input  cfgw_size_e     acc_size,
    input  logic           cfg_en,
    input  logic [AW-1:0]  formed_addr,
    input  logic [DW-1:0]  formed_wdata,
    output logic           acc_ready,
    output logic           acc_done,
    output logic [DW-1:0]  acc_rdata,
    output cfgw_size_e     held_size,
    output logic           req_valid,
    input  logic           req_ready,
    output logic           req_we,
    output logic [AW-1:0]  req_addr,
    output logic [SZW-1:0] req_size,
    output logic [DW-1:0]  req_wdata,
    input  logic           rsp_valid,
    input  logic [DW-1:0]  rsp_data
);

    cfgw_state_e   state_q;
    logic          we_q;
    cfgw_size_e    size_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          accept;

    // An access is taken only while idle.
    always_comb accept = acc_req && (state_q == ST_IDLE);

    // State transitions of the single-outstanding sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (accept) state_q <= cfg_en ? ST_ISSUE : ST_DONE;
                ST_ISSUE: if (req_ready) state_q <= we_q ? ST_DONE : ST_WAIT;
                ST_WAIT:  if (rsp_valid) state_q <= ST_DONE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Latch the request fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            size_q  <= SZ_BYTE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            we_q    <= acc_we;
            size_q  <= acc_size;
            addr_q  <= formed_addr;
            wdata_q <= formed_wdata;
        end
    end

    // Result register: local default, zero for writes, or captured response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE:  if (accept && !cfg_en)
                              rdata_q <= acc_we ? '0 : cfgw_mask(acc_size);
                ST_ISSUE: if (req_ready && we_q) rdata_q <= '0;
                ST_WAIT:  if (rsp_valid) rdata_q <= rsp_data;
                default:  rdata_q <= rdata_q;
            endcase
        end
    end

    assign acc_ready = (state_q == ST_IDLE);
    assign acc_done  = (state_q == ST_DONE);
    assign acc_rdata = rdata_q;
    assign held_size = size_q;
    assign req_valid = (state_q == ST_ISSUE);
    assign req_we    = we_q;
    assign req_addr  = addr_q;
    assign req_size  = cfgw_bytes(size_q);
    assign req_wdata = wdata_q;

endmodule

// File: rtl/cfg_window_bridge.sv
// cfg_window_bridge: top of the configuration index/data window bridge.
// It ties together the index register, address forming, lane formatting
// and the access sequencer. Assumes a single CPU master that keeps
// win_req high until it sees win_ready.
module cfg_window_bridge
    import cfgw_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                areg_we,
    input  logic [CFGW_AW-1:0]  areg_wdata,
    output logic [CFGW_AW-1:0]  areg_rdata,
    input  logic                win_req,
    input  logic                win_we,
    input  logic [1:0]          win_off,
    input  logic [1:0]          win_size,
    input  logic [CFGW_DW-1:0]  win_wdata,
    output logic                win_ready,
    output logic                win_done,
    output logic [CFGW_DW-1:0]  win_rdata,
    output logic                dn_valid,
    input  logic                dn_ready,
    output logic                dn_we,
    output logic [CFGW_AW-1:0]  dn_addr,
    output logic [CFGW_SZW-1:0] dn_size,
    output logic [CFGW_DW-1:0]  dn_wdata,
    input  logic                dn_rvalid,
    input  logic [CFGW_DW-1:0]  dn_rdata
);

    localparam int EN_BIT = CFGW_AW - 1;

    logic               cfg_en;
    cfgw_size_e         size_n;
    cfgw_size_e         held_size;
    logic [CFGW_AW-1:0] formed_addr;
    logic [CFGW_DW-1:0] formed_wdata;
    logic [CFGW_DW-1:0] rsp_fmt;

    // Fold the reserved size code into a word access.
    always_comb size_n = cfgw_norm(win_size);

    cfgw_index_reg #(.AW(CFGW_AW), .EN_BIT(EN_BIT)) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (areg_we),
        .wr_data (areg_wdata),
        .value   (areg_rdata),
        .enabled (cfg_en)
    );

    cfgw_addr_form #(.AW(CFGW_AW), .OFF_W(2)) u_addr (
        .index_val (areg_rdata),
        .offset    (win_off),
        .size      (size_n),
        .addr      (formed_addr)
    );

    cfgw_lane_fmt #(.BIG_ENDIAN(BIG_ENDIAN), .DW(CFGW_DW)) u_lanes (
        .wr_in   (win_wdata),
        .wr_size (size_n),
        .wr_out  (formed_wdata),
        .rd_in   (dn_rdata),
        .rd_size (held_size),
        .rd_out  (rsp_fmt)
    );

    cfgw_seq #(.AW(CFGW_AW), .DW(CFGW_DW), .SZW(CFGW_SZW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_req      (win_req),
        .acc_we       (win_we),
        .acc_size     (size_n),
        .cfg_en       (cfg_en),
        .formed_addr  (formed_addr),
        .formed_wdata (formed_wdata),
        .acc_ready    (win_ready),
        .acc_done     (win_done),
        .acc_rdata    (win_rdata),
        .held_size    (held_size),
        .req_valid    (dn_valid),
        .req_ready    (dn_ready),
        .req_we       (dn_we),
        .req_addr     (dn_addr),
        .req_size     (dn_size),
        .req_wdata    (dn_wdata),
        .rsp_valid    (dn_rvalid),
        .rsp_data     (rsp_fmt)
    );

endmodule

// File: rtl/cfgw_checker.sv
// cfgw_checker: port-level temporal properties of cfg_window_bridge,
// attached to every instance by the bind statement at the end of this file.
module cfgw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] areg_rdata,
    input logic        win_req,
    input logic        win_we,
    input logic [1:0]  win_size,
    input logic        win_ready,
    input logic        win_done,
    input logic [31:0] win_rdata,
    input logic        dn_valid,
    input logic        dn_ready,
    input logic [31:0] dn_addr,
    input logic [2:0]  dn_size,
    input logic [31:0] dn_wdata
);

    // R2: a write taken while disabled completes without a request.
    a_r2_wr_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (win_req && win_ready && win_we && !areg_rdata[31]) |=> (!dn_valid && win_done));

    // R3: a byte read taken while disabled returns 0xFF locally.
    a_r3_byte_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (win_req && win_ready && !win_we && !areg_rdata[31] && win_size == 2'd0)
        |=> (!dn_valid && win_done && win_rdata == 32'h0000_00FF));

    // R5: an enabled word access sends the index value unchanged.
    a_r5_word_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (win_req && win_ready && areg_rdata[31] && win_size == 2'd2)
        |=> (dn_valid && dn_addr == $past(areg_rdata)));

    // R6: the downstream size is always exactly one of 1, 2 or 4.
    a_r6_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> ($countones(dn_size) == 1));

    // R9: a pending request keeps its fields until accepted.
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_wdata)));

    // R9: no new access is offered while a request is outstanding.
    a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> !win_ready);

endmodule

bind cfg_window_bridge cfgw_checker u_cfgw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .areg_rdata (areg_rdata),
    .win_req    (win_req),
    .win_we     (win_we),
    .win_size   (win_size),
    .win_ready  (win_ready),
    .win_done   (win_done),
    .win_rdata  (win_rdata),
    .dn_valid   (dn_valid),
    .dn_ready   (dn_ready),
    .dn_addr    (dn_addr),
    .dn_size    (dn_size),
    .dn_wdata   (dn_wdata)
);

// File: tb/test_cfg_window_bridge.sv
`timescale 1ns/1ps
module test_cfg_window_bridge;

    localparam logic [31:0] WDATA = 32'hA1B2_C3D4;
    localparam logic [31:0] RSP   = 32'h1122_3344;

    typedef struct packed {
        logic        we;
        logic [1:0]  sz;
        logic [1:0]  off;
        logic [31:0] areg;
        logic        exp_req;
        logic [31:0] exp_addr;
        logic [2:0]  exp_size;
        logic [31:0] exp_wd;
        logic [31:0] be_wd;
        logic [31:0] exp_rd;
        logic [31:0] be_rd;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd0, 2'd1, 32'h8000_1200, 1'b1, 32'h8000_1201, 3'd1, 32'h0000_00D4, 32'h0000_00D4, 32'h0, 32'h0},
        '{1'b1, 2'd1, 2'd2, 32'h8000_1200, 1'b1, 32'h8000_1202, 3'd2, 32'h0000_C3D4, 32'h0000_D4C3, 32'h0, 32'h0},
        '{1'b1, 2'd2, 2'd3, 32'h8000_1200, 1'b1, 32'h8000_1200, 3'd4, 32'hA1B2_C3D4, 32'hD4C3_B2A1, 32'h0, 32'h0},
        '{1'b0, 2'd0, 2'd3, 32'h8000_1200, 1'b1, 32'h8000_1203, 3'd1, 32'h0, 32'h0, 32'h0000_0044, 32'h0000_0044},
        '{1'b0, 2'd1, 2'd1, 32'h8000_1200, 1'b1, 32'h8000_1201, 3'd2, 32'h0, 32'h0, 32'h0000_3344, 32'h0000_4433},
        '{1'b0, 2'd2, 2'd2, 32'h8000_1200, 1'b1, 32'h8000_1200, 3'd4, 32'h0, 32'h0, 32'h1122_3344, 32'h4433_2211},
        '{1'b0, 2'd0, 2'd0, 32'h0000_1200, 1'b0, 32'h0, 3'd0, 32'h0, 32'h0, 32'h0000_00FF, 32'h0000_00FF},
        '{1'b0, 2'd1, 2'd2, 32'h0000_1200, 1'b0, 32'h0, 3'd0, 32'h0, 32'h0, 32'h0000_FFFF, 32'h0000_FFFF},
        '{1'b0, 2'd2, 2'd1, 32'h0000_1200, 1'b0, 32'h0, 3'd0, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        '{1'b1, 2'd2, 2'd0, 32'h7FFF_FFFF, 1'b0, 32'h0, 3'd0, 32'h0, 32'h0, 32'h0, 32'h0},
        '{1'b0, 2'd0, 2'd2, 32'h80AB_CD04, 1'b1, 32'h80AB_CD06, 3'd1, 32'h0, 32'h0, 32'h0000_0044, 32'h0000_0044},
        '{1'b1, 2'd1, 2'd2, 32'h8000_0001, 1'b1, 32'h8000_0003, 3'd2, 32'h0000_C3D4, 32'h0000_D4C3, 32'h0, 32'h0},
        '{1'b0, 2'd3, 2'd3, 32'h8000_0F00, 1'b1, 32'h8000_0F00, 3'd4, 32'h0, 32'h0, 32'h1122_3344, 32'h4433_2211}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        areg_we = 1'b0;
    logic [31:0] areg_wdata = '0;
    logic        win_req = 1'b0;
    logic        win_we = 1'b0;
    logic [1:0]  win_off = '0;
    logic [1:0]  win_size = '0;
    logic [31:0] win_wdata = '0;
    logic        dn_ready = 1'b0;
    logic        dn_rvalid = 1'b0;
    logic [31:0] dn_rdata = '0;

    logic [31:0] areg_rdata, win_rdata, dn_addr, dn_wdata;
    logic        win_ready, win_done, dn_valid, dn_we;
    logic [2:0]  dn_size;
    logic [31:0] be_areg, be_rdata, be_addr, be_wdata;
    logic        be_ready, be_done, be_valid, be_we;
    logic [2:0]  be_size;

    int n_cmp = 0;
    int n_bad = 0;

    // Observations of the last access.
    logic        got_req, got_done, busy_ok, hold_ok;
    logic [31:0] got_addr, got_wd, got_be_wd, got_rd, got_be_rd;
    logic [2:0]  got_size;

    always #2.5 clk = ~clk;

    cfg_window_bridge i_cfg_window_bridge (
        .clk(clk), .rst_n(rst_n), .areg_we(areg_we), .areg_wdata(areg_wdata),
        .areg_rdata(areg_rdata), .win_req(win_req), .win_we(win_we), .win_off(win_off),
        .win_size(win_size), .win_wdata(win_wdata), .win_ready(win_ready),
        .win_done(win_done), .win_rdata(win_rdata), .dn_valid(dn_valid),
        .dn_ready(dn_ready), .dn_we(dn_we), .dn_addr(dn_addr), .dn_size(dn_size),
        .dn_wdata(dn_wdata), .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata)
    );

    cfg_window_bridge #(.BIG_ENDIAN(1'b1)) i_be_bridge (
        .clk(clk), .rst_n(rst_n), .areg_we(areg_we), .areg_wdata(areg_wdata),
        .areg_rdata(be_areg), .win_req(win_req), .win_we(win_we), .win_off(win_off),
        .win_size(win_size), .win_wdata(win_wdata), .win_ready(be_ready),
        .win_done(be_done), .win_rdata(be_rdata), .dn_valid(be_valid),
        .dn_ready(dn_ready), .dn_we(be_we), .dn_addr(be_addr), .dn_size(be_size),
        .dn_wdata(be_wdata), .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic set_index(input logic [31:0] v);
        @(negedge clk);
        areg_we = 1'b1;
        areg_wdata = v;
        @(negedge clk);
        areg_we = 1'b0;
    endtask

    // One window access, with a downstream responder that can delay ready.
    task automatic run_access(input logic we, input logic [1:0] sz, input logic [1:0] off,
                              input int stall);
        int  stl;
        logic hs_next;
        got_req = 0; got_done = 0; busy_ok = 1; hold_ok = 1;
        got_addr = '0; got_wd = '0; got_be_wd = '0; got_size = '0;
        got_rd = '0; got_be_rd = '0;
        stl = stall;
        hs_next = 0;
        @(negedge clk);
        win_req = 1'b1; win_we = we; win_size = sz; win_off = off; win_wdata = WDATA;
        @(posedge clk);
        #1 win_req = 1'b0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            dn_rvalid = 1'b0;
            if (win_done) begin
                got_done = 1; got_rd = win_rdata; got_be_rd = be_rdata;
                break;
            end
            if (win_ready) busy_ok = 0;
            if (hs_next) begin
                hs_next = 0;
                dn_ready = 1'b0;
                if (!we) begin dn_rvalid = 1'b1; dn_rdata = RSP; end
            end else if (dn_valid) begin
                if (!got_req) begin
                    got_req = 1; got_addr = dn_addr; got_size = dn_size;
                    got_wd = dn_wdata; got_be_wd = be_wdata;
                end else if (dn_addr !== got_addr || dn_wdata !== got_wd) begin
                    hold_ok = 0;
                end
                if (stl > 0) begin dn_ready = 1'b0; stl--; end
                else begin dn_ready = 1'b1; hs_next = 1; end
            end
        end
        dn_rvalid = 1'b0;
        dn_ready = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        chk("R1 index after reset", areg_rdata, 32'h0);
        chk("R9 ready after reset", {31'b0, win_ready}, 32'h1);
        chk("R9 no request after reset", {31'b0, dn_valid}, 32'h0);
        chk("R8 no done after reset", {31'b0, win_done}, 32'h0);

        // R1: full-width readback.
        set_index(32'hFFFF_FFFF);
        chk("R1 readback all ones", areg_rdata, 32'hFFFF_FFFF);
        set_index(32'h5A5A_A5A5);
        chk("R1 readback pattern", areg_rdata, 32'h5A5A_A5A5);

        // Table walk.
        for (int v = 0; v < NV; v++) begin
            set_index(VECS[v].areg);
            run_access(VECS[v].we, VECS[v].sz, VECS[v].off, 0);
            chk($sformatf("v%0d R9 completed", v), {31'b0, got_done}, 32'h1);
            chk($sformatf("v%0d R2/R3 request issued", v), {31'b0, got_req}, {31'b0, VECS[v].exp_req});
            chk($sformatf("v%0d R9 busy while in flight", v), {31'b0, busy_ok}, 32'h1);
            if (VECS[v].exp_req) begin
                chk($sformatf("v%0d %s address", v, (VECS[v].exp_size == 3'd4) ? "R5" : "R4"),
                    got_addr, VECS[v].exp_addr);
                chk($sformatf("v%0d R6 size", v), {29'b0, got_size}, {29'b0, VECS[v].exp_size});
                if (VECS[v].we) begin
                    chk($sformatf("v%0d R7 write data", v), got_wd, VECS[v].exp_wd);
                    chk($sformatf("v%0d R10 big-endian write data", v), got_be_wd, VECS[v].be_wd);
                end
            end
            chk($sformatf("v%0d R3/R8 read result", v), got_rd, VECS[v].exp_rd);
            chk($sformatf("v%0d R10 big-endian read result", v), got_be_rd, VECS[v].be_rd);
        end

        // R9: stalled downstream keeps the request steady.
        set_index(32'h8000_0440);
        run_access(1'b1, 2'd2, 2'd0, 4);
        chk("R9 stalled request seen", {31'b0, got_req}, 32'h1);
        chk("R9 stalled request held", {31'b0, hold_ok}, 32'h1);
        chk("R9 stalled completion", {31'b0, got_done}, 32'h1);
        chk("R9 busy during stall", {31'b0, busy_ok}, 32'h1);

        // R1: reset clears index and disables access again.
        set_index(32'h8000_1234);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 index cleared by reset", areg_rdata, 32'h0);
        run_access(1'b0, 2'd1, 2'd0, 0);
        chk("R3 disabled after reset no request", {31'b0, got_req}, 32'h0);
        chk("R3 disabled after reset halfword ones", got_rd, 32'h0000_FFFF);

        finish_run();
    end

endmodule